// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a compact processor built around one 12-bit accumulator and a 256-word memory of 12-bit words. It holds a program counter, an instruction register, a memory address register, a memory buffer register, a stack pointer and a two-flag status register. All of these registers exchange values over one shared internal bus. A control sequencer runs each instruction in two phases. The fetch phase takes four cycles and brings the word at the program counter into the instruction register. The execute phase then takes one to four cycles, depending on the opcode. Every memory access goes through the address and buffer registers to a synchronous single-port array, and that array can be inferred as block RAM.

The program is loaded into memory through a load port while reset is held. After reset is released, the core runs on its own until it reaches HALT. The architectural state is published on registered outputs. These outputs change only in the cycle marked by a one-cycle retire strobe, one strobe per completed instruction, so a surrounding system or a bench can follow execution one instruction at a time. Subroutines use a descending stack kept in the same memory.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high and after it is released, until the first instruction retires, the outputs read acc 0x000, pc 0x00, sp 0xFF, zero 1, neg 0, retire 0 and halted 0. The first instruction is fetched from address 0.
- R2: An instruction word carries its opcode in bits 11:8 and an 8-bit operand address in bits 7:0. The opcodes are: 0x0 load, 0x1 store, 0x2 add, 0x3 and, 0x4 invert, 0x5 jump, 0x6 jump-if-nonzero, 0x7 jump-if-negative, 0x8 call, 0x9 return, 0xA no-op and 0xF halt.
- R3: An instruction whose first fetch cycle ends at clock edge s takes 4+E cycles. E is 4 for load, add, and, call and return, 3 for store, and 1 for all other opcodes. `retire_o` is high for exactly the one cycle after edge s+4+E. acc_o, pc_o, sp_o, zero_o and neg_o change only in that cycle.
- R4: Load copies memory[addr] into the accumulator. Store writes the accumulator to memory[addr].
- R5: Add sets the accumulator to (acc + memory[addr]) mod 4096. And sets it to acc bitwise-AND memory[addr].
- R6: Invert replaces the accumulator with its bitwise complement.
- R7: Every instruction that writes the accumulator (load, add, and, invert) sets zero = (acc == 0) and neg = acc bit 11. All other instructions leave both flags unchanged.
- R8: Jump loads pc with addr. Jump-if-nonzero does so only when the zero flag is 0. Jump-if-negative does so only when the neg flag is 1. Otherwise pc is the address after the instruction.
- R9: Call decrements sp by 1, stores the address after the call at memory[new sp], and jumps to addr. Return loads pc from memory[sp] bits 7:0 and then increments sp by 1.
- R10: Halt raises `halted_o` together with its retire strobe. From then on no instruction runs and no memory write occurs, and all outputs hold until reset.
- R11: The opcodes 0xB to 0xE behave as the no-op: one execute cycle and no state change apart from pc advancing.
- R12: The load port writes memory[load_addr] = load_data only while `rst` is high. While the core runs, `load_we` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables the load port |
| load_we | input | 1 | Memory preload write enable (honoured only in reset) |
| load_addr | input | 8 | Memory preload address |
| load_data | input | 12 | Memory preload word |
| retire_o | output | 1 | One-cycle strobe per completed instruction |
| halted_o | output | 1 | Core has executed halt |
| acc_o | output | 12 | Accumulator after the last retired instruction |
| pc_o | output | 8 | Program counter after the last retired instruction |
| sp_o | output | 8 | Stack pointer after the last retired instruction |
| zero_o | output | 1 | Zero flag after the last retired instruction |
| neg_o | output | 1 | Negative flag after the last retired instruction |

## Verification
Each instruction's results are due exactly 4+E edges after the edge that ends its first fetch cycle. The retire strobe and the new output values appear in the cycle after that edge. The bench runs a behavioural interpreter of the instruction set. When an instruction starts, the interpreter computes that instruction's E and schedules the next start at the resulting edge. At that same edge it moves its state into the expected outputs. Every output is then compared at each falling edge, so a result that arrives one cycle early or late fails just as a wrong value does.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [3:0] {
    OP_READ  = 4'h0,
    OP_WRITE = 4'h1,
    OP_ADD   = 4'h2,
    OP_AND   = 4'h3,
    OP_NEG   = 4'h4,
    OP_JUMP  = 4'h5,
    OP_JNZ   = 4'h6,
    OP_JN    = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_NOP   = 4'hA,
    OP_HALT  = 4'hF
  } opcode_e;

  typedef enum logic [3:0] {
    ST_FADDR, ST_FWAIT, ST_FLOAD, ST_FIR,
    ST_EX0, ST_EX1, ST_EX2, ST_EX3, ST_HALT
  } state_e;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_PC, SRC_ACC, SRC_MBR, SRC_SP, SRC_OPND
  } bus_src_e;

  typedef enum logic [1:0] {
    ALU_PASS, ALU_ADD, ALU_AND, ALU_INV
  } alu_op_e;

  typedef struct packed {
    bus_src_e src;
    alu_op_e  alu;
    logic     mar_ld;
    logic     mbr_bus_ld;
    logic     mbr_mem_ld;
    logic     acc_ld;
    logic     ir_ld;
    logic     pc_inc;
    logic     pc_ld;
    logic     sp_inc;
    logic     sp_dec;
    logic     mem_we;
    logic     done;
  } ctrl_t;

endpackage

// File: rtl/acc_core_alu.sv
module acc_core_alu
  import acc_core_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_AND:  y = a & b;
      ALU_INV:  y = ~a;
      default:  y = b;
    endcase
  end

endmodule

// File: rtl/acc_core_stack.sv
module acc_core_stack #(
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  input  logic              dec,
  output logic [ADDR_W-1:0] sp
);

  always_ff @(posedge clk) begin
    if (rst)      sp <= INIT;
    else if (dec) sp <= sp - 1'b1;
    else if (inc) sp <= sp + 1'b1;
  end

endmodule

// File: rtl/acc_core_ram.sv
module acc_core_ram #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // single port, read-before-write, registered read data
  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
    rdata <= cells[addr];
  end

endmodule

// File: rtl/acc_core_ctrl.sv
module acc_core_ctrl
  import acc_core_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zero_f,
  input  logic             neg_f,
  output ctrl_t            ctl,
  output logic             halted_st
);

  state_e state_q, state_d;

  assign halted_st = (state_q == ST_HALT);

  // A load enable may be raised from several states/opcodes; each branch
  // below sets the same field, which merges those terms into one enable.
  always_comb begin
    ctl     = '0;
    state_d = state_q;
    unique case (state_q)
      ST_FADDR: begin
        ctl.src    = SRC_PC;
        ctl.mar_ld = 1'b1;
        state_d    = ST_FWAIT;
      end
      ST_FWAIT: state_d = ST_FLOAD;
      ST_FLOAD: begin
        ctl.mbr_mem_ld = 1'b1;
        state_d        = ST_FIR;
      end
      ST_FIR: begin
        ctl.src    = SRC_MBR;
        ctl.ir_ld  = 1'b1;
        ctl.pc_inc = 1'b1;
        state_d    = ST_EX0;
      end
      ST_EX0: begin
        state_d = ST_EX1;
        case (opcode)
          OP_READ, OP_ADD, OP_AND, OP_WRITE: begin
            ctl.src    = SRC_OPND;
            ctl.mar_ld = 1'b1;
          end
          OP_RET: begin
            ctl.src    = SRC_SP;
            ctl.mar_ld = 1'b1;
          end
          OP_CALL: ctl.sp_dec = 1'b1;
          OP_NEG: begin
            ctl.alu    = ALU_INV;
            ctl.acc_ld = 1'b1;
            ctl.done   = 1'b1;
            state_d    = ST_FADDR;
          end
          OP_JUMP, OP_JNZ, OP_JN: begin
            ctl.src   = SRC_OPND;
            ctl.pc_ld = (opcode == OP_JUMP) ||
                        (opcode == OP_JNZ && !zero_f) ||
                        (opcode == OP_JN && neg_f);
            ctl.done  = 1'b1;
            state_d   = ST_FADDR;
          end
          OP_HALT: begin
            ctl.done = 1'b1;
            state_d  = ST_HALT;
          end
          default: begin
            ctl.done = 1'b1;
            state_d  = ST_FADDR;
          end
        endcase
      end
      ST_EX1: begin
        state_d = ST_EX2;
        case (opcode)
          OP_WRITE: begin
            ctl.src        = SRC_ACC;
            ctl.mbr_bus_ld = 1'b1;
          end
          OP_CALL: begin
            ctl.src    = SRC_SP;
            ctl.mar_ld = 1'b1;
          end
          default: ;
        endcase
      end
      ST_EX2: begin
        state_d = ST_EX3;
        case (opcode)
          OP_WRITE: begin
            ctl.mem_we = 1'b1;
            ctl.done   = 1'b1;
            state_d    = ST_FADDR;
          end
          OP_CALL: begin
            ctl.src        = SRC_PC;
            ctl.mbr_bus_ld = 1'b1;
          end
          default: ctl.mbr_mem_ld = 1'b1;
        endcase
      end
      ST_EX3: begin
        state_d  = ST_FADDR;
        ctl.done = 1'b1;
        case (opcode)
          OP_READ, OP_ADD, OP_AND: begin
            ctl.src    = SRC_MBR;
            ctl.acc_ld = 1'b1;
            ctl.alu    = (opcode == OP_ADD) ? ALU_ADD :
                         (opcode == OP_AND) ? ALU_AND : ALU_PASS;
          end
          OP_RET: begin
            ctl.src    = SRC_MBR;
            ctl.pc_ld  = 1'b1;
            ctl.sp_inc = 1'b1;
          end
          default: begin
            ctl.mem_we = 1'b1;
            ctl.src    = SRC_OPND;
            ctl.pc_ld  = 1'b1;
          end
        endcase
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FADDR;
    else     state_q <= state_d;
  end

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int                DATA_W  = 12,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] SP_INIT = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_we,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic              retire_o,
  output logic              halted_o,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              zero_o,
  output logic              neg_o
);

  localparam int PAD_W = DATA_W - ADDR_W;

  ctrl_t             ctl;
  logic              halted_st, done_q;
  logic [DATA_W-1:0] bus, alu_y, ram_q, ram_wdata;
  logic [DATA_W-1:0] acc_q, mbr_q, ir_q;
  logic [ADDR_W-1:0] pc_q, mar_q, sp_q, ram_addr;
  logic              zf_q, nf_q, ram_we;

  acc_core_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .opcode(ir_q[ADDR_W +: OPC_W]),
    .zero_f(zf_q), .neg_f(nf_q),
    .ctl(ctl), .halted_st(halted_st)
  );

  acc_core_alu #(.DATA_W(DATA_W)) u_alu (
    .op(ctl.alu), .a(acc_q), .b(bus), .y(alu_y)
  );

  acc_core_stack #(.ADDR_W(ADDR_W), .INIT(SP_INIT)) u_stack (
    .clk(clk), .rst(rst), .inc(ctl.sp_inc), .dec(ctl.sp_dec), .sp(sp_q)
  );

  // preload path owns the memory port only while reset is held
  assign ram_addr  = rst ? load_addr : mar_q;
  assign ram_we    = rst ? load_we   : ctl.mem_we;
  assign ram_wdata = rst ? load_data : mbr_q;

  acc_core_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_q)
  );

  // shared internal bus
  always_comb begin
    unique case (ctl.src)
      SRC_PC:   bus = {{PAD_W{1'b0}}, pc_q};
      SRC_ACC:  bus = acc_q;
      SRC_MBR:  bus = mbr_q;
      SRC_SP:   bus = {{PAD_W{1'b0}}, sp_q};
      SRC_OPND: bus = {{PAD_W{1'b0}}, ir_q[ADDR_W-1:0]};
      default:  bus = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      zf_q  <= 1'b1;
      nf_q  <= 1'b0;
      pc_q  <= '0;
      ir_q  <= '0;
      mar_q <= '0;
      mbr_q <= '0;
    end else begin
      if (ctl.acc_ld) begin
        acc_q <= alu_y;
        zf_q  <= (alu_y == '0);
        nf_q  <= alu_y[DATA_W-1];
      end
      if (ctl.pc_ld)       pc_q <= bus[ADDR_W-1:0];
      else if (ctl.pc_inc) pc_q <= pc_q + 1'b1;
      if (ctl.ir_ld)  ir_q  <= bus;
      if (ctl.mar_ld) mar_q <= bus[ADDR_W-1:0];
      if (ctl.mbr_mem_ld)      mbr_q <= ram_q;
      else if (ctl.mbr_bus_ld) mbr_q <= bus;
    end
  end

  // architectural snapshot, published one cycle after the last execute step
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q   <= 1'b0;
      retire_o <= 1'b0;
      halted_o <= 1'b0;
      acc_o    <= '0;
      pc_o     <= '0;
      sp_o     <= SP_INIT;
      zero_o   <= 1'b1;
      neg_o    <= 1'b0;
    end else begin
      done_q   <= ctl.done;
      retire_o <= done_q;
      if (done_q) begin
        acc_o    <= acc_q;
        pc_o     <= pc_q;
        sp_o     <= sp_q;
        zero_o   <= zf_q;
        neg_o    <= nf_q;
        halted_o <= halted_o | halted_st;
      end
    end
  end

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              retire_o,
  input logic              halted_o,
  input logic [DATA_W-1:0] acc_o,
  input logic [ADDR_W-1:0] pc_o,
  input logic [ADDR_W-1:0] sp_o,
  input logic              zero_o,
  input logic              neg_o,
  input logic              mem_we
);

  AST_RETIRE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    retire_o |=> !retire_o); // R3

  AST_OUTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !retire_o |-> ($stable(acc_o) && $stable(pc_o) && $stable(sp_o))); // R3

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    zero_o == (acc_o == '0)); // R7

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
    neg_o == acc_o[DATA_W-1]); // R7

  AST_SP_STEP: assert property (@(posedge clk) disable iff (rst)
    retire_o |-> (sp_o == $past(sp_o) || sp_o == $past(sp_o) + ADDR_W'(1) ||
                  sp_o == $past(sp_o) - ADDR_W'(1))); // R9

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    halted_o |=> (halted_o && !retire_o)); // R10

  AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    halted_o |-> !mem_we); // R10

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .retire_o(retire_o), .halted_o(halted_o),
  .acc_o(acc_o), .pc_o(pc_o), .sp_o(sp_o), .zero_o(zero_o), .neg_o(neg_o),
  .mem_we(ram_we)
);

// File: tb/acc_core_tb_top.sv
`timescale 1ns/1ps
module acc_core_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_we = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [11:0] load_data = '0;
  logic        retire_o, halted_o, zero_o, neg_o;
  logic [11:0] acc_o;
  logic [7:0]  pc_o, sp_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  logic [11:0] img [256];

  always #4 clk = ~clk;

  acc_core dut_i (
    .clk(clk), .rst(rst), .load_we(load_we), .load_addr(load_addr),
    .load_data(load_data), .retire_o(retire_o), .halted_o(halted_o),
    .acc_o(acc_o), .pc_o(pc_o), .sp_o(sp_o), .zero_o(zero_o), .neg_o(neg_o)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_err++;
      $display("FAIL R3 watchdog expired actual=%0d expected<=60000", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
      $finish;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // R2: opcode in bits 11:8, operand address in bits 7:0
  function automatic logic [11:0] enc(int op, int ad);
    return {op[3:0], ad[7:0]};
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1:    return "R4";
      2, 3:    return "R5";
      4:       return "R6";
      5, 6, 7: return "R8";
      8, 9:    return "R9";
      15:      return "R10";
      10:      return "R2";
      default: return "R11";
    endcase
  endfunction

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 12'hF00;
  endtask

  task automatic run(bit drive_r12, int fin_acc, string fin_tag);
    int mem [256];
    int k, next_start, post, op, ad, ex;
    int macc, mpc, msp, mz, mn, mhalt;
    int sacc, spc, ssp, sz, sn, shalt, exp_ret;
    string pend_tag, last_tag;
    rst = 1'b1;
    load_we = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      load_we   = 1'b1;
      load_addr = i[7:0];
      load_data = img[i];
      mem[i]    = int'(img[i]);
      @(negedge clk);
    end
    load_we = 1'b0;
    @(negedge clk);
    chk("R1", "reset acc_o", int'(acc_o), 0);
    chk("R1", "reset pc_o", int'(pc_o), 0);
    chk("R1", "reset sp_o", int'(sp_o), 255);
    chk("R1", "reset zero_o/neg_o", {zero_o, neg_o}, 2);
    chk("R1", "reset retire_o/halted_o", {retire_o, halted_o}, 0);
    macc = 0; mpc = 0; msp = 255; mz = 1; mn = 0; mhalt = 0;
    sacc = 0; spc = 0; ssp = 255; sz = 1; sn = 0; shalt = 0;
    next_start = 1; k = 0; post = 0;
    pend_tag = "R1"; last_tag = "R1";
    rst = 1'b0;
    while (1) begin
      @(posedge clk);
      k++;
      exp_ret = 0;
      if (k == next_start) begin
        if (k > 1) begin
          exp_ret = 1;
          sacc = macc; spc = mpc; ssp = msp; sz = mz; sn = mn; shalt = mhalt;
          last_tag = pend_tag;
        end
        if (mhalt != 0) next_start = -1;
        else begin
          op  = (mem[mpc] >> 8) & 15;
          ad  = mem[mpc] & 255;
          mpc = (mpc + 1) & 255;
          ex  = 1;
          case (op)
            0: begin macc = mem[ad]; ex = 4; end
            1: begin mem[ad] = macc; ex = 3; end
            2: begin macc = (macc + mem[ad]) & 12'hFFF; ex = 4; end
            3: begin macc = macc & mem[ad]; ex = 4; end
            4: macc = (~macc) & 12'hFFF;
            5: mpc = ad;
            6: if (mz == 0) mpc = ad;
            7: if (mn != 0) mpc = ad;
            8: begin msp = (msp - 1) & 255; mem[msp] = mpc; mpc = ad; ex = 4; end
            9: begin mpc = mem[msp] & 255; msp = (msp + 1) & 255; ex = 4; end
            15: mhalt = 1;
            default: ;
          endcase
          if (op <= 4) begin
            mz = (macc == 0) ? 1 : 0;
            mn = (macc >> 11) & 1;
          end
          pend_tag   = tag_of(op);
          next_start = k + 4 + ex;
        end
      end
      @(negedge clk);
      chk("R3", "retire_o", int'(retire_o), exp_ret);
      chk(last_tag, "acc_o", int'(acc_o), sacc);
      chk(last_tag, "pc_o", int'(pc_o), spc);
      chk(last_tag, "sp_o", int'(sp_o), ssp);
      chk("R7", "zero_o", int'(zero_o), sz);
      chk("R7", "neg_o", int'(neg_o), sn);
      chk("R10", "halted_o", int'(halted_o), shalt);
      // R12: writes attempted through the load port while running
      load_we   = drive_r12 && k >= 2 && k <= 5;
      load_addr = 8'h56;
      load_data = 12'hABC;
      if (next_start == -1) post++;
      if (post == 5) break;
      if (k > 4000) begin
        chk("R3", "program did not halt", k, 0);
        break;
      end
    end
    load_we = 1'b0;
    chk(fin_tag, "final acc_o", int'(acc_o), fin_acc);
    chk("R10", "final halted_o", int'(halted_o), 1);
  endtask

  task automatic abs_prog(logic [11:0] val);
    clear_img();
    img[8'h00] = enc(0, 8'h0C);
    img[8'h01] = enc(1, 8'h0D);
    img[8'h02] = enc(3, 8'h0E);
    img[8'h03] = enc(6, 8'h05);
    img[8'h04] = enc(15, 0);
    img[8'h05] = enc(0, 8'h0C);
    img[8'h06] = enc(4, 0);
    img[8'h07] = enc(2, 8'h0F);
    img[8'h08] = enc(1, 8'h0D);
    img[8'h09] = enc(0, 8'h0D);
    img[8'h0A] = enc(15, 0);
    img[8'h0C] = val;
    img[8'h0D] = 12'h000;
    img[8'h0E] = 12'h800;
    img[8'h0F] = 12'h001;
  endtask

  initial begin
    // R5: most negative value, abs path through invert + add one
    abs_prog(12'h800);
    run(1'b0, 12'h800, "R5");
    // R8: positive input, jump-if-nonzero not taken, halt at 0x04
    abs_prog(12'h123);
    run(1'b0, 12'h000, "R8");
    // R9/R11/R12: subroutines, flags, wrap-around add, undefined opcode
    clear_img();
    img[8'h00] = enc(0, 8'h50);
    img[8'h01] = enc(8, 8'h20);
    img[8'h02] = enc(8, 8'h30);
    img[8'h03] = enc(1, 8'h51);
    img[8'h04] = enc(0, 8'h56);
    img[8'h05] = enc(3, 8'h52);
    img[8'h06] = enc(6, 8'h09);
    img[8'h07] = enc(11, 0);
    img[8'h08] = enc(5, 8'h0A);
    img[8'h09] = enc(15, 0);
    img[8'h0A] = enc(2, 8'h54);
    img[8'h0B] = enc(2, 8'h55);
    img[8'h0C] = enc(7, 8'h09);
    img[8'h0D] = enc(4, 0);
    img[8'h0E] = enc(7, 8'h10);
    img[8'h0F] = enc(15, 0);
    img[8'h10] = enc(0, 8'h56);
    img[8'h11] = enc(10, 0);
    img[8'h12] = enc(15, 0);
    img[8'h20] = enc(7, 8'h22);
    img[8'h21] = enc(9, 0);
    img[8'h22] = enc(4, 0);
    img[8'h23] = enc(2, 8'h53);
    img[8'h24] = enc(9, 0);
    img[8'h30] = enc(1, 8'h57);
    img[8'h31] = enc(2, 8'h57);
    img[8'h32] = enc(9, 0);
    img[8'h50] = 12'hFF9;
    img[8'h52] = 12'h800;
    img[8'h53] = 12'h001;
    img[8'h54] = 12'h7FF;
    img[8'h55] = 12'h801;
    img[8'h56] = 12'h055;
    run(1'b1, 12'h055, "R12");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule